// File: doc/BRIEF.md
# Deferred Fetch Abort Tracker

This block rides alongside a three-stage fetch, decode and execute pipeline and carries one fault tag with every instruction slot. When the memory system reports a fault on an instruction fetch, no exception is raised at that point. The fetched instruction is instead marked as faulted, and the mark moves down the pipeline with the instruction's address. The abort is raised only if the instruction reaches execute and is really executed there. The tag therefore disappears without effect in two cases: a taken branch ahead of the instruction flushes it, or its condition check fails at execute.

When the abort is taken, the block produces a one-cycle pulse and the address of the faulting instruction. The address is what the trap handler returns to, so the same instruction is fetched and tried again. In the same cycle the pulse kills the faulting instruction and everything younger than it. Decoding, condition evaluation and vector generation belong to the surrounding core. This block receives only a pass flag for the instruction at execute and a flush signal for a taken branch.

Top module: `fetch_abort_tracker`

## Requirements
- R1: After reset every stage slot is empty, `abort_take` is 0 and `abort_addr` is 0.
- R2: A fetch fault is recorded only when `fetch_valid` is 1 at the same time. A recorded fault never raises `abort_take` while its instruction is in fetch or decode.
- R3: Slot contents move one stage further (fetch to decode to execute) only in cycles where `advance` is 1. While `advance` is 0 and `flush` is 0, every slot holds its value.
- R4: If the execute slot holds a valid faulted instruction, `cond_pass` is 1 and `advance` is 1, then `abort_take` is 1 in the following cycle. It is 0 in the cycle after that.
- R5: When `abort_take` is 1, `abort_addr` equals the fetch address of the faulting instruction. `abort_addr` keeps that value until the next abort is taken.
- R6: A faulted instruction that leaves execute with `cond_pass` at 0 raises no abort and leaves `abort_addr` unchanged.
- R7: `flush` empties the fetch and decode slots at the next edge. If `advance` is 1 in that cycle, the execute slot receives a bubble.
- R8: Taking an abort empties the fetch, decode and execute slots. A faulted instruction that was fetched after the aborting one therefore never raises an abort.
- R9: Fetching the aborted address again without a fault lets that instruction pass through execute with no abort.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| fetch_valid | input | 1 | An instruction is presented at fetch this cycle |
| fetch_addr | input | ADDR_W | Address of the presented instruction |
| fetch_fault | input | 1 | The memory system reported a fault for this fetch |
| advance | input | 1 | Pipeline advance enable; 0 stalls every stage |
| flush | input | 1 | A taken branch discards the fetch and decode slots |
| cond_pass | input | 1 | The instruction in execute passes its condition check |
| abort_take | output | 1 | One-cycle pulse: the fetch abort is taken now |
| abort_addr | output | ADDR_W | Address of the instruction whose abort was taken |

## Verification
On every cycle the assertions check the following. A fault tag is never held in an empty slot. Slots hold still while stalled. Every pulse is traced back to an executing, condition-passing, faulted instruction, and its address matches. A pulse never lasts two cycles. Flushes and taken aborts leave the younger slots empty. Only the bench's scenarios can show the end-to-end effects. These are a fault that disappears because its instruction failed its condition or was shadowed by a branch, a fault that arrives late after a long stall, a second fault that is lost behind a taken one, and a clean re-fetch of the aborted address.

// File: rtl/fat_pkg.sv
package fat_pkg;

  // Stage roles in the slot array.
  localparam int STAGE_FETCH  = 0;
  localparam int STAGE_DECODE = 1;

  // The abort is taken only by an instruction that really executes.
  function automatic logic abort_fire(input logic slot_valid,
                                      input logic slot_fault,
                                      input logic cond_ok,
                                      input logic adv);
    return slot_valid & slot_fault & cond_ok & adv;
  endfunction

  // Younger slots are emptied by any kill. The execute slot is emptied
  // only when it would otherwise have accepted the killed decode slot.
  function automatic logic slot_clear(input int   idx,
                                      input int   last_idx,
                                      input logic kill,
                                      input logic adv);
    if (idx < last_idx) return kill;
    return kill & adv;
  endfunction

  // A fault flag without a fetched instruction is meaningless.
  function automatic logic fault_qualify(input logic fv, input logic ff);
    return fv & ff;
  endfunction

endpackage

// File: rtl/fat_stage.sv
module fat_stage #(
  parameter int W = 34
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic         clear,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  always_ff @(posedge clk) begin
    if (!rst_n)      q <= '0;
    else if (clear)  q <= '0;
    else if (load)   q <= d;
  end

endmodule

// File: rtl/fat_resolve.sv
module fat_resolve
  import fat_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              e_valid,
  input  logic              e_fault,
  input  logic [ADDR_W-1:0] e_addr,
  input  logic              advance,
  input  logic              cond_pass,
  output logic              fire,
  output logic              abort_take,
  output logic [ADDR_W-1:0] abort_addr
);

  assign fire = abort_fire(e_valid, e_fault, cond_pass, advance);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      abort_take <= 1'b0;
      abort_addr <= '0;
    end else begin
      abort_take <= fire;
      if (fire) abort_addr <= e_addr;
    end
  end

endmodule

// File: rtl/fetch_abort_tracker.sv
module fetch_abort_tracker
  import fat_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int NUM_STAGES = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fetch_valid,
  input  logic [ADDR_W-1:0] fetch_addr,
  input  logic              fetch_fault,
  input  logic              advance,
  input  logic              flush,
  input  logic              cond_pass,
  output logic              abort_take,
  output logic [ADDR_W-1:0] abort_addr
);

  // Slot layout: {valid, fault, addr}
  localparam int TAG_W   = ADDR_W + 2;
  localparam int VLD_BIT = ADDR_W + 1;
  localparam int FLT_BIT = ADDR_W;
  localparam int LAST    = NUM_STAGES - 1;

  logic [TAG_W-1:0] slot_d [NUM_STAGES];
  logic [TAG_W-1:0] slot_q [NUM_STAGES];

  // Named internal events for the checker
  logic              fire;
  logic              kill;
  logic [TAG_W-1:0]  f_tag;
  logic [TAG_W-1:0]  d_tag;
  logic [TAG_W-1:0]  e_tag;
  logic              e_valid;
  logic              e_fault;
  logic [ADDR_W-1:0] e_addr;

  assign kill = flush | fire;

  assign slot_d[0] = {fetch_valid, fault_qualify(fetch_valid, fetch_fault), fetch_addr};

  for (genvar i = 0; i < NUM_STAGES; i++) begin : g_slot
    if (i > 0) begin : g_chain
      assign slot_d[i] = slot_q[i-1];
    end
    fat_stage #(.W(TAG_W)) u_stage (
      .clk   (clk),
      .rst_n (rst_n),
      .load  (advance),
      .clear (slot_clear(i, LAST, kill, advance)),
      .d     (slot_d[i]),
      .q     (slot_q[i])
    );
  end

  assign f_tag   = slot_q[STAGE_FETCH];
  assign d_tag   = slot_q[STAGE_DECODE];
  assign e_tag   = slot_q[LAST];
  assign e_valid = e_tag[VLD_BIT];
  assign e_fault = e_tag[FLT_BIT];
  assign e_addr  = e_tag[ADDR_W-1:0];

  fat_resolve #(.ADDR_W(ADDR_W)) u_resolve (
    .clk        (clk),
    .rst_n      (rst_n),
    .e_valid    (e_valid),
    .e_fault    (e_fault),
    .e_addr     (e_addr),
    .advance    (advance),
    .cond_pass  (cond_pass),
    .fire       (fire),
    .abort_take (abort_take),
    .abort_addr (abort_addr)
  );

endmodule

// File: rtl/fat_checker.sv
module fat_checker #(
  parameter int ADDR_W = 32,
  parameter int TAG_W  = ADDR_W + 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              advance,
  input logic              flush,
  input logic              cond_pass,
  input logic              fire,
  input logic              abort_take,
  input logic [ADDR_W-1:0] abort_addr,
  input logic [TAG_W-1:0]  f_tag,
  input logic [TAG_W-1:0]  d_tag,
  input logic [TAG_W-1:0]  e_tag
);

  localparam int VB = ADDR_W + 1;
  localparam int FB = ADDR_W;

  p_fault_needs_valid_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (f_tag[FB] |-> f_tag[VB]) and (d_tag[FB] |-> d_tag[VB]) and (e_tag[FB] |-> e_tag[VB]));

  p_hold_on_stall_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!advance && !flush) |=> ($stable(f_tag) && $stable(d_tag) && $stable(e_tag)));

  p_take_from_exec_r4: assert property (@(posedge clk) disable iff (!rst_n)
    abort_take |-> $past(e_tag[VB] && e_tag[FB] && cond_pass && advance));

  p_single_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
    abort_take |=> !abort_take);

  p_addr_match_r5: assert property (@(posedge clk) disable iff (!rst_n)
    abort_take |-> (abort_addr == $past(e_tag[ADDR_W-1:0])));

  p_addr_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !fire |=> $stable(abort_addr));

  p_cond_fail_silent_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (e_tag[VB] && e_tag[FB] && !cond_pass) |=> !abort_take);

  p_flush_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (!f_tag[VB] && !d_tag[VB]));

  p_abort_kills_r8: assert property (@(posedge clk) disable iff (!rst_n)
    abort_take |-> (!f_tag[VB] && !d_tag[VB] && !e_tag[VB]));

endmodule

bind fetch_abort_tracker fat_checker #(.ADDR_W(ADDR_W), .TAG_W(TAG_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .advance    (advance),
  .flush      (flush),
  .cond_pass  (cond_pass),
  .fire       (fire),
  .abort_take (abort_take),
  .abort_addr (abort_addr),
  .f_tag      (f_tag),
  .d_tag      (d_tag),
  .e_tag      (e_tag)
);

// File: tb/sim_fetch_abort_tracker.sv
module sim_fetch_abort_tracker;
  localparam int PERIOD = 10;
  localparam int AW     = 32;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          fetch_valid = 1'b0;
  logic [AW-1:0] fetch_addr = '0;
  logic          fetch_fault = 1'b0;
  logic          advance = 1'b0;
  logic          flush = 1'b0;
  logic          cond_pass = 1'b0;
  logic          abort_take;
  logic [AW-1:0] abort_addr;

  int errors = 0;
  int checks = 0;
  int pulses = 0;

  // Reference slots: index 0 fetch, 1 decode, 2 execute
  bit          mv [3];
  bit          mf [3];
  logic [AW-1:0] ma [3];
  bit          exp_take = 1'b0;
  logic [AW-1:0] exp_addr = '0;

  always #(PERIOD/2) clk = ~clk;

  fetch_abort_tracker #(.ADDR_W(AW)) u0 (
    .clk(clk), .rst_n(rst_n), .fetch_valid(fetch_valid), .fetch_addr(fetch_addr),
    .fetch_fault(fetch_fault), .advance(advance), .flush(flush), .cond_pass(cond_pass),
    .abort_take(abort_take), .abort_addr(abort_addr)
  );

  function automatic bit exp_fire(bit v, bit f, bit cp, bit adv);
    return v && f && cp && adv;
  endfunction

  task automatic chk(bit ok, string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cyc(bit fv, bit ff, logic [AW-1:0] fa, bit adv, bit fl, bit cp);
    bit f, k;
    @(negedge clk);
    fetch_valid = fv; fetch_fault = ff; fetch_addr = fa;
    advance = adv; flush = fl; cond_pass = cp;
    @(posedge clk);
    f = exp_fire(mv[2], mf[2], cp, adv);
    k = fl || f;
    exp_take = f;
    if (f) exp_addr = ma[2];
    if (k && adv) begin mv[2] = 0; mf[2] = 0; ma[2] = '0; end
    else if (adv) begin mv[2] = mv[1]; mf[2] = mf[1]; ma[2] = ma[1]; end
    if (k) begin mv[1] = 0; mf[1] = 0; ma[1] = '0; end
    else if (adv) begin mv[1] = mv[0]; mf[1] = mf[0]; ma[1] = ma[0]; end
    if (k) begin mv[0] = 0; mf[0] = 0; ma[0] = '0; end
    else if (adv) begin mv[0] = fv; mf[0] = fv && ff; ma[0] = fa; end
    #(PERIOD/4);
    chk(abort_take == exp_take, "R4 pulse vs model", 64'(abort_take), 64'(exp_take));
    chk(abort_addr == exp_addr, "R5 address vs model", 64'(abort_addr), 64'(exp_addr));
    if (abort_take) pulses++;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) cyc(0, 0, '0, 1, 0, 1);
  endtask

  initial begin
    #(PERIOD * 200000);
    errors++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int p0;
    for (int i = 0; i < 3; i++) begin mv[i] = 0; mf[i] = 0; ma[i] = '0; end
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk(abort_take == 1'b0, "R1 reset pulse", 64'(abort_take), 64'd0);
    chk(abort_addr == '0, "R1 reset address", 64'(abort_addr), 64'd0);

    // Taken fault: fetched, travels, aborts at execute
    p0 = pulses;
    cyc(1, 1, 32'h0000_1000, 1, 0, 1);
    idle(2);
    chk(pulses == p0, "R2 no abort before execute", 64'(pulses - p0), 64'd0);
    idle(1);
    chk(abort_take == 1'b1, "R4 taken at execute", 64'(abort_take), 64'd1);
    chk(abort_addr == 32'h0000_1000, "R5 faulting address", 64'(abort_addr), 64'h1000);
    idle(1);
    chk(abort_take == 1'b0, "R4 single-cycle pulse", 64'(abort_take), 64'd0);
    chk(abort_addr == 32'h0000_1000, "R5 address held", 64'(abort_addr), 64'h1000);

    // Fault on an instruction failing its condition
    p0 = pulses;
    cyc(1, 1, 32'h0000_2000, 1, 0, 1);
    idle(2);
    cyc(0, 0, '0, 1, 0, 0);
    idle(3);
    chk(pulses == p0, "R6 condition fail drops abort", 64'(pulses - p0), 64'd0);
    chk(abort_addr == 32'h0000_1000, "R6 address untouched", 64'(abort_addr), 64'h1000);

    // Fault shadowed by a taken branch while in decode
    p0 = pulses;
    cyc(1, 1, 32'h0000_3000, 1, 0, 1);
    idle(1);
    cyc(0, 0, '0, 1, 1, 1);
    idle(4);
    chk(pulses == p0, "R7 flushed fault discarded", 64'(pulses - p0), 64'd0);

    // Stall holds the tag; abort arrives after the stall
    p0 = pulses;
    cyc(1, 1, 32'h0000_4000, 1, 0, 1);
    for (int i = 0; i < 5; i++) cyc(0, 0, '0, 0, 0, 1);
    chk(pulses == p0, "R3 no movement while stalled", 64'(pulses - p0), 64'd0);
    idle(2);
    chk(abort_take == 1'b0, "R3 tag not yet at execute", 64'(abort_take), 64'd0);
    idle(1);
    chk(abort_take == 1'b1 && abort_addr == 32'h0000_4000, "R3 abort after stall",
        64'(abort_addr), 64'h4000);

    // Two faults back to back: only the older one aborts
    p0 = pulses;
    cyc(1, 1, 32'h0000_5000, 1, 0, 1);
    cyc(1, 1, 32'h0000_5004, 1, 0, 1);
    idle(2);
    chk(abort_take == 1'b1 && abort_addr == 32'h0000_5000, "R8 older fault taken",
        64'(abort_addr), 64'h5000);
    idle(4);
    chk(pulses == p0 + 1, "R8 younger fault killed", 64'(pulses - p0), 64'd1);
    chk(abort_addr == 32'h0000_5000, "R8 address kept", 64'(abort_addr), 64'h5000);

    // Retry: same address fetched again without fault
    p0 = pulses;
    cyc(1, 0, 32'h0000_5000, 1, 0, 1);
    idle(4);
    chk(pulses == p0, "R9 retry runs clean", 64'(pulses - p0), 64'd0);

    // Fault flag with no fetched instruction
    p0 = pulses;
    cyc(0, 1, 32'h0000_6000, 1, 0, 1);
    idle(4);
    chk(pulses == p0, "R2 fault without valid ignored", 64'(pulses - p0), 64'd0);

    // Constrained random traffic against the model
    void'($urandom(32'd20240611));
    for (int i = 0; i < 4000; i++) begin
      bit fv, ff, adv, fl, cp;
      fv  = ($urandom % 100) < 80;
      ff  = ($urandom % 100) < 25;
      adv = ($urandom % 100) < 75;
      fl  = ($urandom % 100) < 8;
      cp  = ($urandom % 100) < 70;
      cyc(fv, ff, {$urandom} & 32'hFFFF_FFFC, adv, fl, cp);
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule